// File: doc/BRIEF.md
# Ordering-table clear DMA generator

This channel fills a region of memory with an empty, backward-linked list and needs no peripheral to do it. Software programs a start address and an entry count. It then writes the one control word that starts a fill. From then on the channel writes one 32-bit entry per accepted memory cycle. The first entry goes at the start address and each following entry sits 4 bytes lower. Every entry points at its lower neighbour, and the entry at the lowest address carries an end-of-list marker.

The lock for the whole block is bit 24 of the control register. Writing any value with that bit set starts an operation. The channel clears the bit when the operation ends and pulses its interrupt for one cycle. If the control value is not exactly the fill command, or the start address is outside memory, or the count is zero, the operation ends with no memory traffic. While bit 24 is set, all register writes are dropped.

Top module: `otc_clear_dma`

## Requirements
- R1: After reset, the address, count and control readbacks are zero, `irq` is low and `mem_req` is low.
- R2: A control write of exactly 0x11000002 starts a fill. Write k (counting from 0) goes to A - 4k, where A is the programmed address with bits 1:0 and bits 31:24 dropped.
- R3: Every entry except the lowest holds its own address minus 4, taken modulo 2^24, in data bits 23:0. Data bits 31:24 are zero.
- R4: The lowest entry, written last at A - 4(N-1), holds 0x00FFFFFF. With N = 1 the only write is this marker at A.
- R5: A fill issues exactly N writes. N is bits 15:0 (CNT_W bits) of the count register.
- R6: A control write that sets bit 24 but is not 0x11000002 causes no writes. It is stored as written. Bit 24 reads 1 after the capturing edge, and the next edge clears it and raises `irq`.
- R7: The fill command with a start address at or above MEM_LIMIT (default 0x200000), or with N = 0, also ends with no writes, with the same timing as R6.
- R8: The clock edge that accepts the final write clears bit 24 of the control register. `irq` is high for exactly the one cycle after that edge.
- R9: While `mem_ready` is low, `mem_req`, `mem_addr` and `mem_wdata` hold steady. One write is accepted on each edge where both `mem_req` and `mem_ready` are high.
- R10: While bit 24 is set, writes to the address, count and control registers are ignored: the readbacks do not change and the running fill is not disturbed.
- R11: A control write with bit 24 clear is stored but starts nothing: no writes and no `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 address, 1 count, 2 control |
| cfg_wdata | input | 32 | Register write data |
| addr_o | output | 32 | Address register readback |
| count_o | output | 32 | Count register readback |
| ctrl_o | output | 32 | Control register readback; bit 24 is busy |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | 24 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory accepts the write this cycle |
| irq | output | 1 | One-cycle completion pulse |

## Verification
A register write can reach the block in the same cycle as the final memory handshake. At that edge the busy bit is still set and is only now being cleared. The bench drives a fill with `mem_ready` held high and times a fresh fill command so that the command is sampled on exactly the edge that accepts the last entry. The test passes if that command is dropped: one interrupt, no further writes, and a control readback that shows the old command with bit 24 cleared.

// File: rtl/otc_pkg.sv
package otc_pkg;

    localparam int          AW        = 24;
    localparam int          BUSY_BIT  = 24;
    localparam logic [31:0] FILL_CMD  = 32'h1100_0002;
    localparam logic [AW-1:0] END_MARK = {AW{1'b1}};
    localparam logic [AW-1:0] STEP     = AW'(4);

    typedef enum logic [1:0] {
        SEL_ADDR  = 2'd0,
        SEL_COUNT = 2'd1,
        SEL_CTRL  = 2'd2,
        SEL_NONE  = 2'd3
    } sel_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_FILL = 1'b1
    } st_e;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic          last;
    } entry_t;

    function automatic logic [AW-1:0] link_of(input logic [AW-1:0] a);
        return a - STEP;
    endfunction

    function automatic logic [AW-1:0] word_align(input logic [31:0] a);
        return {a[AW-1:2], 2'b00};
    endfunction

    function automatic logic is_fill_cmd(input logic [31:0] c);
        return c == FILL_CMD;
    endfunction

endpackage

// File: rtl/otc_cfg_regs.sv
module otc_cfg_regs
    import otc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        we,
    input  logic [1:0]  sel,
    input  logic [31:0] wdata,
    input  logic        fin,
    output logic [31:0] addr_q,
    output logic [31:0] cnt_q,
    output logic [31:0] ctrl_q,
    output logic        start_q
);

    logic busy;
    logic wr_ok;
    sel_e sel_d;

    assign busy  = ctrl_q[BUSY_BIT];
    assign wr_ok = we && !busy;
    assign sel_d = sel_e'(sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            cnt_q   <= '0;
            ctrl_q  <= '0;
            start_q <= 1'b0;
        end else begin
            start_q <= 1'b0;
            if (wr_ok) begin
                case (sel_d)
                    SEL_ADDR:  addr_q <= wdata;
                    SEL_COUNT: cnt_q  <= wdata;
                    SEL_CTRL: begin
                        ctrl_q  <= wdata;
                        start_q <= wdata[BUSY_BIT];
                    end
                    default: ;
                endcase
            end
            if (fin) begin
                ctrl_q[BUSY_BIT] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/otc_entry_fmt.sv
module otc_entry_fmt
    import otc_pkg::*;
(
    input  entry_t      ent,
    output logic [31:0] word
);

    logic [AW-1:0] payload;

    always_comb begin
        if (ent.last) begin
            payload = END_MARK;
        end else begin
            payload = link_of(ent.addr);
        end
        word = {{(32-AW){1'b0}}, payload};
    end

endmodule

// File: rtl/otc_fill_seq.sv
module otc_fill_seq
    import otc_pkg::*;
#(
    parameter int            CNT_W     = 16,
    parameter logic [AW-1:0] MEM_LIMIT = 24'h20_0000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [31:0]      cmd,
    input  logic [AW-1:0]    base,
    input  logic [CNT_W-1:0] cnt,
    input  logic             mem_ready,
    output logic             mem_req,
    output entry_t           ent,
    output logic             fin,
    output logic             irq
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    st_e              st;
    logic [AW-1:0]    cur;
    logic [CNT_W-1:0] left;
    logic             good;
    logic             last;
    logic             take;

    assign good    = is_fill_cmd(cmd) && (base < MEM_LIMIT) && (cnt != '0);
    assign last    = (left == ONE);
    assign mem_req = (st == ST_FILL);
    assign take    = mem_req && mem_ready;
    assign ent     = '{addr: cur, last: last};

    always_comb begin
        fin = 1'b0;
        if (st == ST_IDLE && start && !good) begin
            fin = 1'b1;
        end
        if (take && last) begin
            fin = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            cur  <= '0;
            left <= '0;
            irq  <= 1'b0;
        end else begin
            irq <= fin;
            case (st)
                ST_IDLE: begin
                    if (start && good) begin
                        st   <= ST_FILL;
                        cur  <= base;
                        left <= cnt;
                    end
                end
                ST_FILL: begin
                    if (mem_ready) begin
                        cur  <= cur - STEP;
                        left <= left - ONE;
                        if (last) begin
                            st <= ST_IDLE;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/otc_clear_dma.sv
module otc_clear_dma
    import otc_pkg::*;
#(
    parameter int            CNT_W     = 16,
    parameter logic [23:0]   MEM_LIMIT = 24'h20_0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [1:0]  cfg_sel,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] addr_o,
    output logic [31:0] count_o,
    output logic [31:0] ctrl_o,
    output logic        mem_req,
    output logic [23:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ready,
    output logic        irq
);

    logic        start_q;
    logic        fin;
    entry_t      ent;
    logic [31:0] addr_q;
    logic [31:0] cnt_q;
    logic [31:0] ctrl_q;

    otc_cfg_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .we      (cfg_we),
        .sel     (cfg_sel),
        .wdata   (cfg_wdata),
        .fin     (fin),
        .addr_q  (addr_q),
        .cnt_q   (cnt_q),
        .ctrl_q  (ctrl_q),
        .start_q (start_q)
    );

    otc_fill_seq #(
        .CNT_W     (CNT_W),
        .MEM_LIMIT (MEM_LIMIT)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start_q),
        .cmd       (ctrl_q),
        .base      (word_align(addr_q)),
        .cnt       (cnt_q[CNT_W-1:0]),
        .mem_ready (mem_ready),
        .mem_req   (mem_req),
        .ent       (ent),
        .fin       (fin),
        .irq       (irq)
    );

    otc_entry_fmt u_fmt (
        .ent  (ent),
        .word (mem_wdata)
    );

    assign mem_addr = ent.addr;
    assign addr_o   = addr_q;
    assign count_o  = cnt_q;
    assign ctrl_o   = ctrl_q;

endmodule

// File: rtl/otc_clear_dma_chk.sv
module otc_clear_dma_chk (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        mem_req,
    input logic        mem_ready,
    input logic [23:0] mem_addr,
    input logic [31:0] mem_wdata,
    input logic        irq
);

    AST_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy); // R2

    AST_ADDR_DESCEND: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ready) |=> (!mem_req || mem_addr == $past(mem_addr) - 24'd4)); // R2

    AST_TOP_BYTE_ZERO: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_wdata[31:24] == 8'h00)); // R3

    AST_LINK_VALUE: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_wdata != 32'h00FF_FFFF) |-> (mem_wdata[23:0] == mem_addr - 24'd4)); // R3

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata))); // R9

    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq); // R8

    AST_IRQ_BUSY_CLEAR: assert property (@(posedge clk) disable iff (rst)
        irq |-> (!busy && !mem_req)); // R8

    AST_BUSY_FALL_IRQ: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> irq); // R8

endmodule

bind otc_clear_dma otc_clear_dma_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .busy      (ctrl_o[24]),
    .mem_req   (mem_req),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .irq       (irq)
);

// File: tb/otc_clear_dma_tb.sv
`timescale 1ns/1ps
module otc_clear_dma_tb_top;

    localparam int          CNT_W = 16;
    localparam logic [31:0] FILL  = 32'h1100_0002;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] addr_o, count_o, ctrl_o;
    logic        mem_req;
    logic [23:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ready = 1'b0;
    logic        irq;

    int errors = 0;
    int checks = 0;
    bit ready_full = 1'b1;
    bit finished = 1'b0;

    logic [23:0] exp_base = '0;
    int          exp_n = 0;
    int          wr_idx = 0;
    int          irq_cnt = 0;
    bit          prev_final = 1'b0;
    bit          prev_stall = 1'b0;
    logic [23:0] prev_addr = '0;
    logic [31:0] prev_data = '0;

    always #5 clk = ~clk;

    otc_clear_dma #(.CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .addr_o(addr_o), .count_o(count_o),
        .ctrl_o(ctrl_o), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    function automatic logic [31:0] exp_entry(input logic [23:0] b, input int i, input int n);
        logic [23:0] a;
        a = b - 24'(4 * i);
        if (i == n - 1) return 32'h00FF_FFFF;
        return {8'h00, a - 24'd4};
    endfunction

    always @(posedge clk) begin
        #2;
        mem_ready = ready_full ? 1'b1 : (($urandom % 100) < 60);
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (prev_stall) begin
                chk(mem_req && mem_addr == prev_addr && mem_wdata == prev_data,
                    "R9", "request not held during stall", {8'h0, mem_addr}, {8'h0, prev_addr});
            end
            if (exp_n > 0 && (irq || prev_final)) begin
                chk(irq == prev_final, "R8", "irq not in cycle after final write",
                    {31'h0, irq}, {31'h0, prev_final});
            end
            if (irq) irq_cnt++;
            prev_final = 1'b0;
            if (mem_req && mem_ready) begin
                chk(wr_idx < exp_n, "R5", "write beyond entry count", wr_idx, exp_n);
                if (wr_idx < exp_n) begin
                    chk(mem_addr == exp_base - 24'(4 * wr_idx), "R2", "write address",
                        {8'h0, mem_addr}, {8'h0, exp_base - 24'(4 * wr_idx)});
                    chk(mem_wdata == exp_entry(exp_base, wr_idx, exp_n),
                        (wr_idx == exp_n - 1) ? "R4" : "R3", "entry value",
                        mem_wdata, exp_entry(exp_base, wr_idx, exp_n));
                    prev_final = (wr_idx == exp_n - 1);
                end
                wr_idx++;
            end
            prev_stall = mem_req && !mem_ready;
            prev_addr  = mem_addr;
            prev_data  = mem_wdata;
        end
    end

    task automatic wr(input logic [1:0] s, input logic [31:0] d);
        @(posedge clk); #2;
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
        @(posedge clk); #2;
        cfg_we = 1'b0;
    endtask

    task automatic arm(input logic [31:0] a, input int n_expected);
        exp_base = {a[23:2], 2'b00};
        exp_n    = n_expected;
        wr_idx   = 0;
        irq_cnt  = 0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 6000 && irq_cnt == 0; i++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic run_fill(input logic [31:0] a, input logic [31:0] n, input bit full, input string tag);
        ready_full = full;
        wr(2'd0, a);
        wr(2'd1, n);
        arm(a, int'(n[CNT_W-1:0]));
        wr(2'd2, FILL);
        wait_done();
        chk(wr_idx == exp_n, "R5", {tag, " write count"}, wr_idx, exp_n);
        chk(irq_cnt == 1, "R8", {tag, " irq pulses"}, irq_cnt, 1);
        chk(ctrl_o == 32'h1000_0002, "R8", {tag, " busy cleared"}, ctrl_o, 32'h1000_0002);
    endtask

    task automatic run_reject(input logic [31:0] a, input logic [31:0] n,
                              input logic [31:0] c, input string req);
        ready_full = 1'b1;
        wr(2'd0, a);
        wr(2'd1, n);
        arm(a, 0);
        wr(2'd2, c);
        @(negedge clk);
        chk(ctrl_o[24] == 1'b1 && irq == 1'b0, req, "busy set after capture", ctrl_o, c);
        @(negedge clk);
        chk(ctrl_o == (c & ~32'h0100_0000), req, "busy cleared next edge", ctrl_o, c & ~32'h0100_0000);
        chk(irq == 1'b1, req, "irq on reject", {31'h0, irq}, 32'h1);
        repeat (4) @(negedge clk);
        chk(wr_idx == 0, req, "no writes on reject", wr_idx, 0);
        chk(irq_cnt == 1, req, "single irq on reject", irq_cnt, 1);
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(ctrl_o == 0 && addr_o == 0 && count_o == 0, "R1", "register reset", ctrl_o, 0);
        chk(irq == 0 && mem_req == 0, "R1", "outputs reset", {30'h0, irq, mem_req}, 0);

        // R4: single entry writes only the marker
        run_fill(32'h0000_0200, 32'd1, 1'b1, "R4 single");
        // R2 address masking of upper and low bits
        run_fill(32'hAB00_0103, 32'd6, 1'b1, "R2 masked");
        // R9 stalls
        run_fill(32'h0000_0800, 32'd20, 1'b0, "R9 stalled");
        // R5 count uses low CNT_W bits
        run_fill(32'h0000_0400, 32'h0003_0004, 1'b1, "R5 low bits");

        // R6 non-fill commands with bit 24
        run_reject(32'h100, 32'd4, 32'h1100_0001, "R6");
        run_reject(32'h100, 32'd4, 32'h0100_0002, "R6");
        // R7 invalid address and zero count
        run_reject(32'h0080_0000, 32'd4, FILL, "R7");
        run_reject(32'h0000_0100, 32'h0001_0000, FILL, "R7");

        // R11 control write without bit 24
        arm(32'h0, 0);
        wr(2'd2, 32'h0000_0002);
        repeat (6) @(negedge clk);
        chk(ctrl_o == 32'h2, "R11", "stored", ctrl_o, 32'h2);
        chk(irq_cnt == 0 && wr_idx == 0, "R11", "no activity", irq_cnt + wr_idx, 0);

        // R10 writes while busy are ignored
        ready_full = 1'b0;
        wr(2'd0, 32'h400);
        wr(2'd1, 32'd40);
        arm(32'h400, 40);
        wr(2'd2, FILL);
        wr(2'd0, 32'h123);
        wr(2'd1, 32'd7);
        wr(2'd2, 32'h0100_0000);
        @(negedge clk);
        chk(addr_o == 32'h400, "R10", "address kept", addr_o, 32'h400);
        chk(count_o == 32'd40, "R10", "count kept", count_o, 32'd40);
        chk(ctrl_o == FILL, "R10", "control kept", ctrl_o, FILL);
        wait_done();
        chk(wr_idx == 40 && irq_cnt == 1, "R10", "fill undisturbed", wr_idx, 40);

        // R8 command landing on the final-write edge is dropped
        ready_full = 1'b1;
        wr(2'd0, 32'h300);
        wr(2'd1, 32'd5);
        arm(32'h300, 5);
        wr(2'd2, FILL);
        repeat (5) @(posedge clk);
        #2;
        cfg_we = 1'b1; cfg_sel = 2'd2; cfg_wdata = FILL;
        @(posedge clk); #2;
        cfg_we = 1'b0;
        repeat (8) @(negedge clk);
        chk(wr_idx == 5 && irq_cnt == 1, "R8", "collision no restart", wr_idx, 5);
        chk(ctrl_o == 32'h1000_0002, "R8", "collision control", ctrl_o, 32'h1000_0002);

        // random fills
        for (int k = 0; k < 30; k++) begin
            automatic int w = $urandom % 1024;
            automatic int lim = (w + 1 < 64) ? w + 1 : 64;
            automatic int n = 1 + ($urandom % lim);
            run_fill(32'(w * 4) | ($urandom % 4), 32'(n), ($urandom % 2) == 0, "R2 random");
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule